// File: doc/BRIEF.md
# Vertex Attribute Staging Buffer

This block holds the per-vertex input attributes that feed a programmable vertex core. It stores sixteen slots, each a 128-bit quad of four 32-bit floating-point components, already converted to float before they arrive. A host writes any slot, at any time the block is idle, through a valid/ready port. Every accepted write marks that slot as changed since the last vertex.

Issuing a vertex starts a handoff to the core's input bank. The block streams only the changed slots, one per accepted beat, in ascending slot order, and clears each slot's mark as it goes. Slots that were not rewritten are not sent again, because the core's bank still holds them. A one-cycle completion pulse closes each handoff. Host writes are held off during a handoff, so every vertex sees a consistent set of attributes.

Top module: `vtx_attr_stage`

## Requirements
- R1: After reset every slot holds zero and every slot is marked changed, so the first issue streams all 16 slots (indices 0 to 15) with all-zero data; out_valid and done are low and wr_ready is high while idle.
- R2: A write beat (wr_valid and wr_ready high at a clock edge) stores wr_data into slot wr_idx and marks that slot changed; a later write to the same slot before an issue replaces the earlier data.
- R3: An issue pulse while idle starts a handoff; from the next cycle the changed slots appear on out_idx one at a time in strictly ascending index order, each held until an out beat (out_valid and out_ready high) takes it.
- R4: During a handoff out_data carries the full 128-bit content of slot out_idx, with component k in bits 32k+31 down to 32k.
- R5: While out_valid is high and out_ready is low, out_valid, out_idx and out_data stay unchanged into the next cycle.
- R6: A slot's changed mark clears when its out beat is taken; a slot not rewritten since then is not sent on the next handoff.
- R7: done is a one-cycle pulse in the cycle after the last out beat of a handoff, or in the cycle after the issue when no slot is marked; out_valid is low while done is high.
- R8: wr_ready is low in the issue cycle and in every cycle up to and including the done cycle; a write held during the handoff is accepted in the first cycle after done.
- R9: An issue pulse while a handoff is in progress is ignored: no second handoff follows the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| wr_valid | input | 1 | Host offers a slot write |
| wr_ready | output | 1 | Block accepts a slot write this cycle |
| wr_idx | input | 4 | Slot being written |
| wr_data | input | 128 | Four 32-bit float components for the slot |
| issue | input | 1 | Single-cycle vertex issue strobe |
| out_valid | output | 1 | A changed slot is on the output |
| out_ready | input | 1 | Core input bank takes the offered slot |
| out_idx | output | 4 | Index of the offered slot |
| out_data | output | 128 | Content of the offered slot |
| done | output | 1 | One-cycle end-of-handoff pulse |

## Verification
A write beat is visible to the next issue; the first slot of a handoff is offered in the cycle after the issue edge, each following slot in the cycle after the previous beat, and done in the cycle after the final beat or directly after the issue when nothing is marked. The bench drives every input on the falling edge and samples outputs on the falling edge before changing inputs, so each sample sees the state left by exactly one rising edge. Its reference model walks the marked slots of its own copy of the buffer in ascending order and checks each offered index, the data, hold under back-pressure and the exact cycle of done against that model, using ready patterns taken from the vector table.

// File: rtl/vtx_attr_stage.sv
module vtx_attr_stage #(
  parameter int NUM_SLOTS = 16,
  parameter int COMP_W    = 32,
  parameter int NUM_COMPS = 4,
  localparam int SLOT_W   = COMP_W * NUM_COMPS,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SLOT_W-1:0] wr_data,
  input  logic              issue,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx,
  output logic [SLOT_W-1:0] out_data,
  output logic              done
);

  logic [SLOT_W-1:0]    slot_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] dirty_q;
  logic                 busy_q;
  logic [IDX_W-1:0]     pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (dirty_q[i]) pick = IDX_W'(i);
  end

  assign wr_ready  = !busy_q && !issue;
  assign out_valid = busy_q && (|dirty_q);
  assign done      = busy_q && !(|dirty_q);
  assign out_idx   = pick;
  assign out_data  = slot_q[pick];

  wire wr_fire  = wr_valid && wr_ready;
  wire out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dirty_q <= '1;
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
    end else begin
      if (wr_fire) begin
        slot_q[wr_idx]  <= wr_data;
        dirty_q[wr_idx] <= 1'b1;
      end
      if (out_fire) dirty_q[pick] <= 1'b0;
      if (!busy_q && issue) busy_q <= 1'b1;
      else if (done)        busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/vtx_attr_stage_chk.sv
module vtx_attr_stage_chk #(
  parameter int IDX_W  = 4,
  parameter int SLOT_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              issue,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_idx,
  input logic [SLOT_W-1:0] out_data,
  input logic              done
);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_data));

  assert_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> (out_valid && out_idx > $past(out_idx)) || done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || done || issue) |-> !wr_ready);

  assert_no_rerun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

endmodule

bind vtx_attr_stage vtx_attr_stage_chk #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .issue(issue), .out_valid(out_valid), .out_ready(out_ready),
  .out_idx(out_idx), .out_data(out_data), .done(done)
);

// File: tb/vtx_attr_stage_tb_top.sv
module vtx_attr_stage_tb_top;
  localparam int NS = 16;
  localparam int IW = 4;
  localparam int SW = 128;
  localparam int NV = 8;

  localparam logic [15:0] VEC_MASK [NV] = '{16'h0000, 16'h0000, 16'h8001, 16'hFFFF,
                                            16'h0F0F, 16'h0010, 16'h7FFE, 16'h1234};
  localparam logic [7:0]  VEC_RDY  [NV] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF,
                                            8'h55, 8'hB6, 8'h33, 8'h81};

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, issue = 0, out_ready = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [SW-1:0] wr_data = '0;
  logic wr_ready, out_valid, done;
  logic [IW-1:0] out_idx;
  logic [SW-1:0] out_data;

  logic [SW-1:0] exp_mem [NS];
  logic [NS-1:0] exp_dirty;
  int n_chk = 0, n_bad = 0, n_beats;
  bit finished = 0;

  always #5 clk = ~clk;

  vtx_attr_stage dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_data(wr_data), .issue(issue), .out_valid(out_valid),
    .out_ready(out_ready), .out_idx(out_idx), .out_data(out_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [SW-1:0] act, input logic [SW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [SW-1:0] word(input int v, input int s);
    return {32'(v * 1000 + s * 4 + 3), 32'(v * 1000 + s * 4 + 2),
            32'(v * 1000 + s * 4 + 1), 32'(v * 1000 + s * 4)};
  endfunction

  function automatic int lowest(input logic [NS-1:0] m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic wr(input int s, input logic [SW-1:0] d);
    bit took = 0;
    wr_valid = 1; wr_idx = IW'(s); wr_data = d;
    while (!took) begin
      took = wr_ready;
      @(negedge clk);
    end
    wr_valid = 0;
    exp_mem[s] = d;
    exp_dirty[s] = 1'b1;
  endtask

  task automatic run_vertex(input logic [7:0] pat, input string tag);
    logic [IW-1:0] h_idx = '0;
    logic [SW-1:0] h_dat = '0;
    bit hold = 0, fin = 0;
    int e;
    n_beats = 0;
    issue = 1; @(negedge clk); issue = 0;
    for (int c = 0; c < 200 && !fin; c++) begin
      if (hold) chk(out_valid && out_idx == h_idx && out_data == h_dat,
                    {"R5 hold ", tag}, {out_idx, out_data[31:0]}, {h_idx, h_dat[31:0]});
      hold = 0;
      if (done) begin
        chk(exp_dirty == '0 && !out_valid, {"R7 done timing ", tag}, SW'(exp_dirty), '0);
        fin = 1;
        out_ready = 0;
      end else if (out_valid) begin
        e = lowest(exp_dirty);
        chk(e >= 0 && out_idx == IW'(e), {"R3 order, R6 resend ", tag}, SW'(out_idx), SW'(e));
        if (e >= 0) chk(out_data == exp_mem[e], {"R4 data ", tag}, out_data, exp_mem[e]);
        if (pat[c % 8]) begin
          out_ready = 1;
          n_beats++;
          if (e >= 0) exp_dirty[e] = 1'b0;
        end else begin
          out_ready = 0;
          hold = 1; h_idx = out_idx; h_dat = out_data;
        end
      end else begin
        chk(0, {"R3 no slot offered ", tag}, SW'(out_valid), 1);
        out_ready = 0;
      end
      if (!fin) @(negedge clk);
    end
    if (!fin) chk(0, {"R7 done missing ", tag}, 0, 1);
    @(negedge clk);
    chk(!done && !out_valid && wr_ready, {"R7 single pulse, R9 ", tag},
        SW'({done, out_valid, wr_ready}), SW'(3'b001));
  endtask

  initial begin
    logic [SW-1:0] w;
    int cnt;
    for (int i = 0; i < NS; i++) exp_mem[i] = '0;
    exp_dirty = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wr_ready && !out_valid && !done, "R1 idle after reset",
        SW'({wr_ready, out_valid, done}), SW'(3'b100));

    for (int v = 0; v < NV; v++) begin
      for (int s = NS - 1; s >= 0; s--)
        if (VEC_MASK[v][s]) wr(s, word(v, s));
      if (v % 2 == 1 && VEC_MASK[v] != 0) begin
        cnt = lowest(VEC_MASK[v]);
        wr(cnt, word(v + 50, cnt));  // R2 rewrite replaces
      end
      cnt = $countones(exp_dirty);
      run_vertex(VEC_RDY[v], $sformatf("vec%0d", v));
      chk(n_beats == cnt, v == 0 ? "R1 all slots sent" : "R6 beat count",
          SW'(n_beats), SW'(cnt));
    end

    wr(2, word(90, 2));
    wr(9, word(90, 9));
    w = word(91, 5);
    issue = 1; wr_valid = 1; wr_idx = 4'd5; wr_data = w; out_ready = 0;
    #1 chk(!wr_ready, "R8 issue cycle", SW'(wr_ready), 0);
    @(negedge clk); issue = 0;
    chk(out_valid && out_idx == 4'd2 && !wr_ready, "R8 stall, R3 first slot",
        SW'({out_valid, out_idx, wr_ready}), SW'({1'b1, 4'd2, 1'b0}));
    @(negedge clk); issue = 1;
    @(negedge clk); issue = 0;
    chk(!wr_ready && out_idx == 4'd2, "R8 still stalled, R9", SW'({wr_ready, out_idx}), SW'(5'd2));
    out_ready = 1;
    @(negedge clk);
    chk(out_valid && out_idx == 4'd9 && out_data == word(90, 9), "R4 second slot", out_data, word(90, 9));
    @(negedge clk); out_ready = 0;
    chk(done && !wr_ready, "R8 done cycle", SW'({done, wr_ready}), SW'(2'b10));
    @(negedge clk);
    chk(!done && !out_valid && wr_ready, "R9 no rerun, R8 released",
        SW'({done, out_valid, wr_ready}), SW'(3'b001));
    @(negedge clk); wr_valid = 0;
    exp_dirty = '0;
    exp_mem[5] = w; exp_dirty[5] = 1'b1;
    run_vertex(8'hFF, "held write");
    chk(n_beats == 1, "R8 held write sent once", SW'(n_beats), 1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule